// File: doc/BRIEF.md
# Segment and Page Address Router

This block sits at the front of an address translation unit. For every 32-bit virtual address presented with an access type, it makes one of three choices. It can pass the address through unchanged. It can remap the address linearly through a per-region base nibble. Or it can hand the address to a paged TLB lookup and later turn the frame number that comes back into a physical address.

The 4-bit region number is the top nibble of the address. A 16-bit mask marks which regions are remapped linearly. Two 32-bit base registers hold one base nibble per region: one register for the lower eight regions, the other for the upper eight.

Paged requests go out as a one-cycle pulse. The pulse carries the address, the access type and a flag that picks the instruction TLB or the data TLB. The frame-number response returns through a separate valid/data input pair.

All outputs are registered. A request produces its result or its lookup pulse one clock after it is accepted.

Top module: `seg_page_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, `res_full_perm` and `page_req` are 0.
- R2: Translation is on only when bit 2 or bit 3 of `cfg_word` is 1. When it is off, a request yields `res_valid`=1, `res_paddr`=`vaddr` and `res_full_perm`=1 one cycle later, and no `page_req`.
- R3: The region number is `vaddr[31:28]`. With translation on, a region whose bit in `seg_en` is 1 is mapped linearly. A region whose bit is 0 is routed to the paged lookup.
- R4: Regions 0 to 7 take their base nibble from `base_lo` and regions 8 to 15 from `base_hi`. The nibble for region r sits at bits [4k+3:4k] with k = r mod 8.
- R5: A linearly mapped request yields, one cycle later, `res_valid`=1, `res_full_perm`=1 and `res_paddr` = {base nibble, `vaddr[27:0]`}.
- R6: A paged request raises `page_req` for exactly one cycle, one cycle after the request. In that cycle `page_vaddr` and `page_acc` carry the request's address and type, and `res_valid` stays 0.
- R7: Access types are encoded as 0 read, 1 write, 2 execute, 3 treated as read. `page_itlb` is 1 for execute (2) and 0 for every other code.
- R8: A `pfn_valid` pulse with frame number `pfn` yields, one cycle later, `res_valid`=1, `res_full_perm`=0 and `res_paddr` = `pfn` shifted left by 13 (8 KB pages).
- R9: If `pfn_valid` and a non-paged request arrive in the same cycle, the frame response wins and the direct result is dropped. A paged request in the same cycle still raises `page_req`.
- R10: Results are single-cycle pulses. With no request and no response, `res_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| vaddr | input | 32 | Virtual address |
| acc_type | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| cfg_word | input | 32 | Global configuration; bits 2 and 3 enable translation |
| seg_en | input | 16 | Per-region linear-mapping enable |
| base_lo | input | 32 | Base nibbles for regions 0 to 7 |
| base_hi | input | 32 | Base nibbles for regions 8 to 15 |
| pfn_valid | input | 1 | Frame-number response strobe from the TLB |
| pfn | input | 19 | Physical frame number from the TLB |
| res_valid | output | 1 | Physical address result valid |
| res_paddr | output | 32 | Physical address |
| res_full_perm | output | 1 | Result carries full read, write and execute permission |
| page_req | output | 1 | Paged lookup request pulse |
| page_vaddr | output | 32 | Address for the paged lookup |
| page_acc | output | 2 | Access type for the paged lookup |
| page_itlb | output | 1 | 1 selects the instruction TLB, 0 the data TLB |

## Verification
The bench builds the router with its default parameters: a 32-bit address, 4-bit region number and 13-bit page offset. With these values all sixteen regions, both base registers and the full 19-bit frame number can be reached directly. Directed cases cover the region edges 0, 7, 8 and 15, each enable bit on its own, all four access codes and the response-versus-request collision. Seeded random traffic then mixes enable words, masks and base values, so that bypass, linear and paged routing alternate from one request to the next.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RT_BYPASS = 2'd0,
    RT_LINEAR = 2'd1,
    RT_PAGED  = 2'd2
  } route_e;
endpackage

// File: rtl/seg_base_pick.sv
module seg_base_pick #(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 1 << SEG_W,
  parameter int HALF    = NUM_SEG / 2,
  parameter int BASE_W  = HALF * SEG_W
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [BASE_W-1:0] base_lo,
  input  logic [BASE_W-1:0] base_hi,
  output logic [SEG_W-1:0]  nibble
);
  localparam int IW = SEG_W - 1;

  logic [SEG_W-1:0] nib_lo [HALF];
  logic [SEG_W-1:0] nib_hi [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_split
    assign nib_lo[g] = base_lo[g*SEG_W +: SEG_W];
    assign nib_hi[g] = base_hi[g*SEG_W +: SEG_W];
  end

  always_comb begin
    if (seg[SEG_W-1]) nibble = nib_hi[seg[IW-1:0]];
    else              nibble = nib_lo[seg[IW-1:0]];
  end
endmodule

// File: rtl/route_decode.sv
module route_decode
  import spr_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int CFG_W   = 32,
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 1 << SEG_W,
  parameter int BASE_W  = (NUM_SEG / 2) * SEG_W
) (
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [NUM_SEG-1:0] seg_en,
  input  logic [BASE_W-1:0]  base_lo,
  input  logic [BASE_W-1:0]  base_hi,
  input  logic [VA_W-1:0]    vaddr,
  input  acc_e               acc,
  output route_e             route,
  output logic [VA_W-1:0]    phys,
  output logic               itlb
);
  localparam int OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] nibble;
  logic             xlate_on;

  assign seg      = vaddr[VA_W-1 -: SEG_W];
  assign xlate_on = cfg_word[2] | cfg_word[3];
  assign itlb     = (acc == ACC_EX);

  seg_base_pick #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .BASE_W(BASE_W)) u_pick (
    .seg     (seg),
    .base_lo (base_lo),
    .base_hi (base_hi),
    .nibble  (nibble)
  );

  always_comb begin
    if (!xlate_on) begin
      route = RT_BYPASS;
      phys  = vaddr;
    end else if (seg_en[seg]) begin
      route = RT_LINEAR;
      phys  = {nibble, vaddr[OFF_W-1:0]};
    end else begin
      route = RT_PAGED;
      phys  = vaddr;
    end
  end
endmodule

// File: rtl/seg_page_router.sv
module seg_page_router
  import spr_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int CFG_W      = 32,
  parameter int SEG_W      = 4,
  parameter int PAGE_SHIFT = 13,
  parameter int NUM_SEG    = 1 << SEG_W,
  parameter int BASE_W     = (NUM_SEG / 2) * SEG_W,
  parameter int PFN_W      = VA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [1:0]         acc_type,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [NUM_SEG-1:0] seg_en,
  input  logic [BASE_W-1:0]  base_lo,
  input  logic [BASE_W-1:0]  base_hi,
  input  logic               pfn_valid,
  input  logic [PFN_W-1:0]   pfn,
  output logic               res_valid,
  output logic [VA_W-1:0]    res_paddr,
  output logic               res_full_perm,
  output logic               page_req,
  output logic [VA_W-1:0]    page_vaddr,
  output logic [1:0]         page_acc,
  output logic               page_itlb
);
  localparam int OFF_W = VA_W - SEG_W;

  route_e          route;
  logic [VA_W-1:0] phys;
  logic            itlb;
  logic            go_paged;
  logic            go_direct;

  route_decode #(
    .VA_W(VA_W), .CFG_W(CFG_W), .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .BASE_W(BASE_W)
  ) u_dec (
    .cfg_word (cfg_word),
    .seg_en   (seg_en),
    .base_lo  (base_lo),
    .base_hi  (base_hi),
    .vaddr    (vaddr),
    .acc      (acc_e'(acc_type)),
    .route    (route),
    .phys     (phys),
    .itlb     (itlb)
  );

  assign go_paged  = req_valid && (route == RT_PAGED);
  assign go_direct = req_valid && (route != RT_PAGED);

  // Paged lookup request: one-cycle pulse with its payload
  always_ff @(posedge clk) begin
    if (rst) begin
      page_req   <= 1'b0;
      page_vaddr <= '0;
      page_acc   <= '0;
      page_itlb  <= 1'b0;
    end else begin
      page_req <= go_paged;
      if (go_paged) begin
        page_vaddr <= vaddr;
        page_acc   <= acc_type;
        page_itlb  <= itlb;
      end
    end
  end

  // Result path: frame response has priority over a direct result
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_paddr     <= '0;
      res_full_perm <= 1'b0;
    end else if (pfn_valid) begin
      res_valid     <= 1'b1;
      res_paddr     <= {pfn, {PAGE_SHIFT{1'b0}}};
      res_full_perm <= 1'b0;
    end else if (go_direct) begin
      res_valid     <= 1'b1;
      res_paddr     <= phys;
      res_full_perm <= 1'b1;
    end else begin
      res_valid     <= 1'b0;
      res_full_perm <= 1'b0;
    end
  end

  // R6
  page_req_src_chk: assert property (@(posedge clk) disable iff (rst)
    page_req |-> $past(req_valid));

  // R7
  tlb_pick_chk: assert property (@(posedge clk) disable iff (rst)
    page_req |-> (page_itlb == (page_acc == 2'd2)));

  // R5
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_full_perm) |-> (res_paddr[OFF_W-1:0] == $past(vaddr[OFF_W-1:0])));

  // R8
  page_align_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_full_perm) |-> (res_paddr[PAGE_SHIFT-1:0] == '0));

  // R10
  perm_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    res_full_perm |-> res_valid);
endmodule

// File: tb/tb_seg_page_router.sv
`timescale 1ns/1ps
module tb_seg_page_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] vaddr;
  logic [1:0]  acc_type;
  logic [31:0] cfg_word;
  logic [15:0] seg_en;
  logic [31:0] base_lo;
  logic [31:0] base_hi;
  logic        pfn_valid;
  logic [18:0] pfn;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_full_perm;
  logic        page_req;
  logic [31:0] page_vaddr;
  logic [1:0]  page_acc;
  logic        page_itlb;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  seg_page_router dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .acc_type(acc_type), .cfg_word(cfg_word), .seg_en(seg_en),
    .base_lo(base_lo), .base_hi(base_hi), .pfn_valid(pfn_valid), .pfn(pfn),
    .res_valid(res_valid), .res_paddr(res_paddr), .res_full_perm(res_full_perm),
    .page_req(page_req), .page_vaddr(page_vaddr), .page_acc(page_acc),
    .page_itlb(page_itlb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(input logic [3:0] s);
    if (s < 4'd8) return 4'((base_lo >> (4 * s)) & 32'hF);
    else          return 4'((base_hi >> (4 * (s - 4'd8))) & 32'hF);
  endfunction

  // 0 bypass, 1 linear, 2 paged
  function automatic int exp_kind(input logic [31:0] va);
    if (!(cfg_word[2] || cfg_word[3])) return 0;
    if (seg_en[va[31:28]]) return 1;
    return 2;
  endfunction

  task automatic issue(input logic [31:0] va, input logic [1:0] ac, input string lbl);
    int k;
    logic [31:0] ex_pa;
    logic [18:0] fr;
    string tag;
    k = exp_kind(va);
    ex_pa = (k == 1) ? {exp_nib(va[31:28]), va[27:0]} : va;
    req_valid = 1'b1; vaddr = va; acc_type = ac;
    @(negedge clk);
    req_valid = 1'b0;
    if (k != 2) begin
      tag = (lbl != "") ? lbl : ((k == 0) ? "R2" : "R5");
      chk(res_valid == 1'b1, tag, 32'(res_valid), 32'd1);
      chk(res_full_perm == 1'b1, tag, 32'(res_full_perm), 32'd1);
      chk(res_paddr == ex_pa, tag, res_paddr, ex_pa);
      chk(page_req == 1'b0, "R3", 32'(page_req), 32'd0);
    end else begin
      tag = (lbl != "") ? lbl : "R6";
      chk(page_req == 1'b1, tag, 32'(page_req), 32'd1);
      chk(res_valid == 1'b0, "R6", 32'(res_valid), 32'd0);
      chk(page_vaddr == va, "R6", page_vaddr, va);
      chk(page_acc == ac, "R6", 32'(page_acc), 32'(ac));
      chk(page_itlb == (ac == 2'd2), "R7", 32'(page_itlb), 32'(ac == 2'd2));
      fr = 19'($urandom);
      pfn_valid = 1'b1; pfn = fr;
      @(negedge clk);
      pfn_valid = 1'b0;
      chk(page_req == 1'b0, "R6", 32'(page_req), 32'd0);
      chk(res_valid == 1'b1, "R8", 32'(res_valid), 32'd1);
      chk(res_full_perm == 1'b0, "R8", 32'(res_full_perm), 32'd0);
      chk(res_paddr == {fr, 13'd0}, "R8", res_paddr, {fr, 13'd0});
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R10", 32'(res_valid), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    rst = 1'b1; req_valid = 1'b0; vaddr = '0; acc_type = '0; cfg_word = '0;
    seg_en = '0; base_lo = '0; base_hi = '0; pfn_valid = 1'b0; pfn = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", 32'(res_valid), 32'd0);
    chk(page_req == 1'b0, "R1", 32'(page_req), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && res_full_perm == 1'b0, "R1", 32'(res_valid), 32'd0);

    // R2: disabled unless bit 2 or bit 3 set
    seg_en = 16'h0000;
    cfg_word = 32'hFFFF_FFF3;
    issue(32'h9ABC_DEF0, 2'd1, "R2");
    cfg_word = 32'h0000_0004;
    issue(32'h9ABC_DEF0, 2'd0, "R2");
    cfg_word = 32'h0000_0008;
    issue(32'h1234_5678, 2'd2, "R2");

    // R3/R4: region edges through linear mapping
    base_lo = 32'hFEDC_BA98; base_hi = 32'h0123_4567;
    seg_en = 16'h8181;
    issue(32'h0ABC_1234, 2'd0, "R4");
    issue(32'h7000_0001, 2'd1, "R4");
    issue(32'h8FFF_FFFF, 2'd2, "R4");
    issue(32'hF123_4567, 2'd0, "R4");
    issue(32'h4123_4567, 2'd0, "R3");

    // R7: all access codes on the paged path
    seg_en = 16'h0000;
    for (int a = 0; a < 4; a++) issue(32'h2468_ACE0, 2'(a), "R7");

    // R9: frame response collides with a linear request
    seg_en = 16'hFFFF;
    req_valid = 1'b1; vaddr = 32'h3000_1000; acc_type = 2'd0;
    pfn_valid = 1'b1; pfn = 19'h5_1234;
    @(negedge clk);
    req_valid = 1'b0; pfn_valid = 1'b0;
    chk(res_valid && !res_full_perm, "R9", 32'(res_full_perm), 32'd0);
    chk(res_paddr == {19'h5_1234, 13'd0}, "R9", res_paddr, {19'h5_1234, 13'd0});
    @(negedge clk);
    chk(res_valid == 1'b0, "R9", 32'(res_valid), 32'd0);

    // R9: frame response collides with a paged request
    seg_en = 16'h0000;
    req_valid = 1'b1; vaddr = 32'h5555_0000; acc_type = 2'd2;
    pfn_valid = 1'b1; pfn = 19'h0_0ABC;
    @(negedge clk);
    req_valid = 1'b0; pfn_valid = 1'b0;
    chk(page_req == 1'b1 && page_itlb == 1'b1, "R9", 32'(page_req), 32'd1);
    chk(res_paddr == {19'h0_0ABC, 13'd0}, "R9", res_paddr, {19'h0_0ABC, 13'd0});
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      cfg_word = $urandom;
      if (($urandom % 4) == 0) cfg_word[3:2] = 2'b00;
      seg_en  = 16'($urandom);
      base_lo = $urandom;
      base_hi = $urandom;
      issue($urandom, 2'($urandom), "");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule